// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block latches requests arriving on six active-low external interrupt lines and holds them as pending flags until they are serviced. Each line has its own sense selection: in level mode a flag is raised for as long as the line is held low, and in edge mode a flag is raised once for each high-to-low transition. The six flags appear on a pending vector for the interrupt controller and on an 8-bit register that software can read and write.

Software can only lower flags, and only those it has seen high. A read records which flags were 1 at that moment, and the next write of 0 to a recorded bit clears it. The exception logic also clears a line's flag when it acknowledges that line. In edge mode the acknowledge always clears the flag. In level mode it clears the flag only if the line has already returned high. Each line passes through a two-flop synchroniser before detection. When a set condition and a clear condition meet in the same cycle, the set wins, so no request is lost.

Top module: `irq_flag_reg`

## Requirements
- R1: Register bit n (n = 0..5) reads line n's flag, bits 7 and 6 always read 0 whatever is written, and the pending output bit n equals register bit n.
- R2: An asynchronous reset, or a cycle with the synchronous standby input high, forces all flags to 0, and they stay 0 for as long as standby is held.
- R3: Writing 1 to a flag bit never sets that flag.
- R4: A write clears flag n only if bit n of the write data is 0 and flag n read as 1 at the most recent read since the previous write; every write disarms all lines, and a read that saw 0 arms nothing.
- R5: With sense bit n at 0 (level mode), flag n is set while the synchronised line n is low.
- R6: With sense bit n at 1 (edge mode), flag n is set once per high-to-low transition of line n; a line held low does not set the flag again after it is cleared.
- R7: In level mode, an acknowledge on line n clears flag n only when the synchronised line is high; while the line is low the flag stays 1.
- R8: In edge mode, an acknowledge on line n clears flag n whatever the line level.
- R9: When a set condition and a clear condition act on the same flag in the same cycle, the flag ends up 1.
- R10: A change on a request line reaches the pending output on the third rising clock edge after it is applied, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous clear of all flags and read arms while high |
| req_n_i | input | 6 | Active-low external request lines, asynchronous |
| sense_edge_i | input | 6 | Per-line sense: 0 level, 1 falling edge |
| ack_i | input | 6 | Per-line acknowledge from exception handling, one cycle |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, bits 7:6 zero |
| pending_o | output | 6 | Per-line pending flags |

## Verification
The bench aims at the read-before-clear rule. It writes 0 with no read first, writes after a read that saw the flag at 0, and writes a second time after a write has already disarmed the lines. A design without arming would clear the flag in all three. It also acknowledges a level line while the line is still low, which a careless design would wrongly clear, and it lines up an acknowledge with the very cycle an edge is detected, where a design that favours the clear would drop the request. The edge line is then held low after an acknowledge, to catch a design that re-sets it from the level alone, and the latency is sampled on both sides of the third edge.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned LINES_DEF   = 6;
  localparam int unsigned REG_W_DEF   = 8;
  localparam int unsigned SYNC_ST_DEF = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  // Idle level of the request lines is high, so stages reset to ones.
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [N-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_set_detect.sv
module irq_set_detect #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] sense_edge_i,
  output logic [N-1:0] set_o,
  output logic [N-1:0] line_hi_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb prev_d = line_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_line
      logic fall;
      always_comb begin
        fall = prev_q[i] & ~line_i[i];
        if (sense_edge_i[i]) set_o[i] = fall;
        else                 set_o[i] = ~line_i[i];
      end
    end
  endgenerate

  assign line_hi_o = line_i;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] line_hi_i,
  input  logic [N-1:0] sense_edge_i,
  input  logic         rd_en_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_bits_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q, flag_d, flag_en;
  logic [N-1:0] arm_q,  arm_d,  arm_en;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic sw_clr, hw_clr;
      always_comb begin
        sw_clr = wr_en_i & arm_q[i] & ~wr_bits_i[i];
        hw_clr = ack_i[i] & (sense_edge_i[i] | line_hi_i[i]);
        // Set dominates any clear in the same cycle.
        if (standby_i) flag_d[i] = 1'b0;
        else           flag_d[i] = (flag_q[i] & ~(sw_clr | hw_clr)) | set_i[i];
        flag_en[i] = standby_i | set_i[i] | sw_clr | hw_clr;

        // A read records the flags it saw; a write consumes the record.
        if (standby_i)    arm_d[i] = 1'b0;
        else if (rd_en_i) arm_d[i] = flag_q[i];
        else              arm_d[i] = 1'b0;
        arm_en[i] = standby_i | rd_en_i | wr_en_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q[i] <= 1'b0;
        else if (flag_en[i]) flag_q[i] <= flag_d[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         arm_q[i] <= 1'b0;
        else if (arm_en[i]) arm_q[i] <= arm_d[i];
      end
    end
  endgenerate

  assign flags_o = flag_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
#(
  parameter int unsigned N      = LINES_DEF,
  parameter int unsigned REG_W  = REG_W_DEF,
  parameter int unsigned SYNC_N = SYNC_ST_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic [N-1:0]     req_n_i,
  input  logic [N-1:0]     sense_edge_i,
  input  logic [N-1:0]     ack_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [N-1:0]     pending_o
);
  localparam int unsigned PAD_W = REG_W - N;

  logic [N-1:0] line_sync;
  logic [N-1:0] set_vec;
  logic [N-1:0] line_hi;
  logic [N-1:0] flags;
  logic         unused_wr_pad;

  assign unused_wr_pad = ^wr_data_i[REG_W-1:N];

  irq_sync #(.N(N), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_n_i),
    .q_o   (line_sync)
  );

  irq_set_detect #(.N(N)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_sync),
    .sense_edge_i (sense_edge_i),
    .set_o        (set_vec),
    .line_hi_o    (line_hi)
  );

  irq_flag_bank #(.N(N)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_i    (standby_i),
    .set_i        (set_vec),
    .ack_i        (ack_i),
    .line_hi_i    (line_hi),
    .sense_edge_i (sense_edge_i),
    .rd_en_i      (rd_en_i),
    .wr_en_i      (wr_en_i),
    .wr_bits_i    (wr_data_i[N-1:0]),
    .flags_o      (flags)
  );

  assign rd_data_o = {{PAD_W{1'b0}}, flags};
  assign pending_o = flags;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk #(
  parameter int unsigned N     = 6,
  parameter int unsigned REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby_i,
  input logic [N-1:0]     ack_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic [N-1:0]     pending_o,
  input logic [N-1:0]     set_vec
);
  // R1: reserved bits stay zero, flag bits mirror the pending vector
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[REG_W-1:N] == '0);
  p_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[N-1:0] == pending_o);

  // R2: standby leaves every flag low on the following cycle
  p_standby_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> pending_o == '0);

  // R3: a flag only rises after a detected set condition
  p_rise_needs_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o & ~$past(pending_o) & ~$past(set_vec)) == '0);

  // R9: a set condition outside standby always leaves the flag high
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && set_vec != '0) |=> (pending_o & $past(set_vec)) == $past(set_vec));

  // R4: a flag falls only by write, acknowledge or standby
  p_fall_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending_o) & ~pending_o &
     ~($past(ack_i) | {N{$past(wr_en_i) | $past(standby_i)}})) == '0);
endmodule

bind irq_flag_reg irq_flag_chk #(.N(N), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby_i (standby_i),
  .ack_i     (ack_i),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .pending_o (pending_o),
  .set_vec   (set_vec)
);

// File: tb/tb_irq_flag_reg.sv
module tb_irq_flag_reg;
  localparam int N = 6;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         standby_i;
  logic [N-1:0] req_n_i, sense_edge_i, ack_i;
  logic         rd_en_i, wr_en_i;
  logic [W-1:0] wr_data_i, rd_data_o;
  logic [N-1:0] pending_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_flag_reg dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .req_n_i(req_n_i),
    .sense_edge_i(sense_edge_i), .ack_i(ack_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .pending_o(pending_o)
  );

  // {sense_edge, req_n}
  localparam logic [11:0] VEC [6] = '{
    {6'b000000, 6'b111110},
    {6'b111111, 6'b101010},
    {6'b010101, 6'b000000},
    {6'b101010, 6'b110011},
    {6'b001111, 6'b011101},
    {6'b110000, 6'b111111}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ack(input logic [N-1:0] m);
    ack_i = m; tick(1); ack_i = '0;
  endtask

  task automatic reg_read(input string req, input logic [W-1:0] exp);
    rd_en_i = 1'b1; #1;
    check(req, rd_data_o, exp);
    tick(1); rd_en_i = 1'b0;
  endtask

  task automatic reg_write(input logic [W-1:0] d);
    wr_en_i = 1'b1; wr_data_i = d; tick(1); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; standby_i = 1'b0; req_n_i = '1; sense_edge_i = '0; ack_i = '0;
    rd_en_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    tick(3);
    check("R2 reset pending", {2'b0, pending_o}, 8'h00);
    check("R2 reset rd_data", rd_data_o, 8'h00);
    rst_n = 1'b1;
    tick(2);

    // Table: set, acknowledge with lines unchanged, release and acknowledge.
    for (int k = 0; k < 6; k++) begin
      logic [N-1:0] s, r;
      {s, r} = VEC[k];
      sense_edge_i = s; tick(1);
      req_n_i = r; tick(4);
      check("R5/R6 set by pattern", {2'b0, pending_o}, {2'b0, ~r});
      check("R1 rd mirror", rd_data_o, {2'b0, ~r});
      pulse_ack('1);
      check("R7/R8 ack with lines held", {2'b0, pending_o}, {2'b0, ~r & ~s});
      req_n_i = '1; tick(3);
      pulse_ack('1);
      check("R7 ack after release", {2'b0, pending_o}, 8'h00);
    end

    // R3: writing ones after a read sets nothing; reserved bits stay 0 (R1).
    reg_read("R3 read zero", 8'h00);
    reg_write(8'hFF);
    tick(1);
    check("R3 write ones", {2'b0, pending_o}, 8'h00);
    check("R1 reserved after write", rd_data_o, 8'h00);

    // R10 latency and R9 set beats ack, edge mode line 0.
    sense_edge_i = 6'h3F; tick(1);
    req_n_i = 6'b111110;
    tick(2);
    check("R10 not after two edges", {2'b0, pending_o}, 8'h00);
    ack_i = 6'h01; tick(1); ack_i = '0;
    check("R9 set wins over ack", {2'b0, pending_o}, 8'h01);
    pulse_ack(6'h01);
    check("R8 edge ack while low", {2'b0, pending_o}, 8'h00);
    tick(4);
    check("R6 held low no reset", {2'b0, pending_o}, 8'h00);
    req_n_i = '1; tick(3);

    // R10 in level mode: visible exactly after the third edge.
    sense_edge_i = 6'h00; tick(1);
    req_n_i = 6'b111011;
    tick(2);
    check("R10 level two edges", {2'b0, pending_o}, 8'h00);
    tick(1);
    check("R10 level three edges", {2'b0, pending_o}, 8'h04);

    // R2 standby with line still low.
    standby_i = 1'b1; tick(1);
    check("R2 standby clears", {2'b0, pending_o}, 8'h00);
    tick(2);
    check("R2 standby holds", {2'b0, pending_o}, 8'h00);
    standby_i = 1'b0; tick(1);
    check("R5 resets after standby", {2'b0, pending_o}, 8'h04);
    pulse_ack(6'h04);
    check("R7 level ack while low", {2'b0, pending_o}, 8'h04);
    req_n_i = '1; tick(3);
    pulse_ack(6'h04);
    check("R7 level ack when high", {2'b0, pending_o}, 8'h00);

    // R4 read-before-clear rules, edge mode lines 0 and 1.
    sense_edge_i = 6'h03; tick(1);
    req_n_i = 6'b111100; tick(4);
    req_n_i = '1; tick(3);
    check("R4 setup", {2'b0, pending_o}, 8'h03);
    reg_write(8'h00);
    check("R4 no read no clear", {2'b0, pending_o}, 8'h03);
    reg_read("R4 read", 8'h03);
    reg_write(8'hFE);
    check("R4 armed zero clears", {2'b0, pending_o}, 8'h02);
    reg_write(8'h00);
    check("R4 disarmed by write", {2'b0, pending_o}, 8'h02);
    reg_read("R4 read 2", 8'h02);
    reg_write(8'h00);
    check("R4 second clear", {2'b0, pending_o}, 8'h00);

    // R4: a read that saw 0 does not arm a later-set flag.
    reg_read("R4 read zero", 8'h00);
    req_n_i = 6'b111110; tick(4);
    req_n_i = '1; tick(3);
    reg_write(8'h00);
    check("R4 read-as-0 no clear", {2'b0, pending_o}, 8'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule